// File: doc/BRIEF.md
# Four-Register Serial Bridge Port

This block joins an 8-bit host bus to a peer processor over a handful of wires. It keeps four byte-wide registers. Two of them carry data from the host to the peer: the host writes them and the peer reads them. The other two carry data from the peer to the host: the peer writes them and the host reads them. A host-writable one-bit register drives a reset line toward the peer. Host software sets that bit when it starts up, so the peer restarts its service state.

The peer names a register with a 2-bit select and moves bytes one bit at a time. It uses a shift clock, a serial line in each direction and a latch strobe. A single internal shift register serves both directions.

- **Outbound:** a latch strobe with an outbound register selected copies that register into the shift register. Shift clocks then walk the byte out, MSB first.
- **Inbound:** shift clocks move serial bits into the shift register. A latch strobe with an inbound register selected then copies the assembled byte into that register.

All peer inputs are asynchronous, so they are resynchronised to the system clock before any edge is acted on.

Top module: `serial_bridge_port`

## Requirements
- R1: The select and the host address share one map. Value 0 is outbound data, 1 is outbound control, 2 is inbound data and 3 is inbound control. The upper bit set means inbound.
- R2: When host_we is high, host_wdata is written on the next clock edge into the register named by host_addr. This applies to any of the four registers. When host_re is high, the register named by host_addr is captured into host_rdata on the next clock edge. Otherwise host_rdata holds its value.
- R3: A latch rise with an outbound register selected loads that register into the shift register, and peer_sdo then shows its bit 7. Each later shift-clock rise moves the next lower bit onto peer_sdo.
- R4: Each shift-clock rise shifts peer_sdi into bit 0 of the shift register. The first bit shifted in ends up as bit 7 after eight rises.
- R5: A latch rise with an inbound register selected copies the shift register into that register only. The other inbound register keeps its value.
- R6: If a host write and a peer latch transfer target the same register in the same cycle, the register takes the host value.
- R7: host_ctl_wr loads host_ctl_bit into the reset-control bit on the next edge, and peer_rst follows that bit.
- R8: Peer inputs pass through two synchronizer flops and then an edge detector, so each rising edge acts exactly once. A latch held high does not transfer again until it has fallen and risen.
- R9: A synchronous reset clears all four registers, the shift register, host_rdata and the reset-control bit to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 8 | Host write byte |
| host_we | input | 1 | Host write enable |
| host_re | input | 1 | Host read enable |
| host_rdata | output | 8 | Registered host read byte |
| host_ctl_wr | input | 1 | Strobe to load the reset-control bit |
| host_ctl_bit | input | 1 | Value for the reset-control bit |
| peer_sel | input | 2 | Asynchronous register select from the peer |
| peer_sclk | input | 1 | Asynchronous shift clock from the peer |
| peer_latch | input | 1 | Asynchronous latch strobe from the peer |
| peer_sdi | input | 1 | Serial data from the peer |
| peer_sdo | output | 1 | Serial data to the peer |
| peer_rst | output | 1 | Reset line to the peer |

## Verification
The bench walks an outbound byte bit by bit. A reversed shift direction or an off-by-one load would show a scrambled sequence on peer_sdo.

It holds the latch strobe high while new bits arrive. A level-sensitive transfer, instead of an edge-triggered one, would overwrite the inbound register early.

It times a host write to land in the same cycle as a peer transfer to the same register. Wrong priority would leave the peer byte in place.

It also checks that a capture into one inbound register leaves the other untouched. Finally, it applies reset mid-session; a partial clear would leave stale bytes readable or the peer reset line high.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic [1:0] {
    SEL_OUT_DATA = 2'd0,
    SEL_OUT_CTRL = 2'd1,
    SEL_IN_DATA  = 2'd2,
    SEL_IN_CTRL  = 2'd3
  } sel_e;

  // Upper select bit clear means the host feeds the peer.
  function automatic logic is_outbound(input logic [1:0] sel);
    return ~sel[1];
  endfunction
endpackage

// File: rtl/sbp_sync.sv
module sbp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign sync_out = stage[STAGES-1];
endmodule

// File: rtl/sbp_regfile.sv
module sbp_regfile #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_we,
  input  logic            host_re,
  input  logic [1:0]      host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  input  logic            cap_en,
  input  logic [1:0]      cap_sel,
  input  logic [DW-1:0]   cap_data,
  input  logic [1:0]      out_sel,
  output logic [DW-1:0]   out_word,
  output logic [4*DW-1:0] regs_flat
);
  localparam int NREG = 4;
  localparam int AW   = 2;

  logic [DW-1:0] r [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        r[g] <= '0;
      else if (host_we && host_addr == AW'(g))
        r[g] <= host_wdata;
      else if (cap_en && cap_sel == AW'(g))
        r[g] <= cap_data;
    end
    assign regs_flat[g*DW +: DW] = r[g];
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_re) host_rdata <= r[host_addr];
  end

  assign out_word = r[out_sel];
endmodule

// File: rtl/sbp_shifter.sv
module sbp_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [DW-1:0] load_data,
  input  logic          shift_en,
  input  logic          ser_in,
  output logic          ser_out,
  output logic [DW-1:0] shreg_q
);
  function automatic logic [DW-1:0] step(input logic [DW-1:0] cur, input logic bit_in);
    return {cur[DW-2:0], bit_in};
  endfunction

  always_ff @(posedge clk) begin
    if (rst)           shreg_q <= '0;
    else if (load_en)  shreg_q <= load_data;
    else if (shift_en) shreg_q <= step(shreg_q, ser_in);
  end

  assign ser_out = shreg_q[DW-1];
endmodule

// File: rtl/serial_bridge_port.sv
module serial_bridge_port #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_we,
  input  logic          host_re,
  output logic [DW-1:0] host_rdata,
  input  logic          host_ctl_wr,
  input  logic          host_ctl_bit,
  input  logic [1:0]    peer_sel,
  input  logic          peer_sclk,
  input  logic          peer_latch,
  input  logic          peer_sdi,
  output logic          peer_sdo,
  output logic          peer_rst
);
  import sbp_pkg::*;

  localparam int SYNC_W = 5;

  logic [SYNC_W-1:0] sync_bus;
  logic [1:0]        sel_s;
  logic              sdi_s, sclk_s, latch_s;
  logic              sclk_d, latch_d;
  logic              sclk_rise, latch_rise;
  logic              load_en, cap_en, shift_en;
  logic [DW-1:0]     out_word, shreg_q;
  logic [4*DW-1:0]   regs_flat;
  logic              ctl_q;

  sbp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({peer_sel, peer_sdi, peer_sclk, peer_latch}),
    .sync_out (sync_bus)
  );

  assign {sel_s, sdi_s, sclk_s, latch_s} = sync_bus;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      latch_d <= 1'b0;
    end else begin
      sclk_d  <= sclk_s;
      latch_d <= latch_s;
    end
  end

  assign sclk_rise  = sclk_s & ~sclk_d;
  assign latch_rise = latch_s & ~latch_d;
  assign load_en    = latch_rise & is_outbound(sel_s);
  assign cap_en     = latch_rise & ~is_outbound(sel_s);
  assign shift_en   = sclk_rise & ~latch_rise;

  sbp_regfile #(.DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_re    (host_re),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .cap_en     (cap_en),
    .cap_sel    (sel_s),
    .cap_data   (shreg_q),
    .out_sel    (sel_s),
    .out_word   (out_word),
    .regs_flat  (regs_flat)
  );

  sbp_shifter #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .load_data (out_word),
    .shift_en  (shift_en),
    .ser_in    (sdi_s),
    .ser_out   (peer_sdo),
    .shreg_q   (shreg_q)
  );

  always_ff @(posedge clk) begin
    if (rst)              ctl_q <= 1'b0;
    else if (host_ctl_wr) ctl_q <= host_ctl_bit;
  end

  assign peer_rst = ctl_q;
endmodule

// File: rtl/sbp_checker.sv
module sbp_checker #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            host_we,
  input logic [1:0]      host_addr,
  input logic [DW-1:0]   host_wdata,
  input logic            host_ctl_wr,
  input logic            host_ctl_bit,
  input logic            peer_rst,
  input logic            peer_sdo,
  input logic            latch_rise,
  input logic            sclk_rise,
  input logic [1:0]      sel_s,
  input logic [DW-1:0]   shreg_q,
  input logic [4*DW-1:0] regs_flat
);
  function automatic logic [DW-1:0] word(input logic [4*DW-1:0] f, input logic [1:0] s);
    return f[s*DW +: DW];
  endfunction

  function automatic logic top_bit(input logic [4*DW-1:0] f, input logic [1:0] s);
    logic [DW-1:0] w;
    w = word(f, s);
    return w[DW-1];
  endfunction

  AST_CTL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    host_ctl_wr |=> peer_rst == $past(host_ctl_bit)); // R7

  AST_HOST_WRITE: assert property (@(posedge clk) disable iff (rst)
    host_we |=> word(regs_flat, $past(host_addr)) == $past(host_wdata)); // R6

  AST_LOAD_MSB: assert property (@(posedge clk) disable iff (rst)
    (latch_rise && !sel_s[1]) |=> peer_sdo == $past(top_bit(regs_flat, sel_s))); // R3

  AST_SHIFT_ADV: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !latch_rise) |=> peer_sdo == $past(shreg_q[DW-2])); // R4

  AST_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(host_we && host_addr == 2'd3) && !(latch_rise && sel_s == 2'd3))
      |=> $stable(word(regs_flat, 2'd3))); // R5

  AST_RISE_ONCE: assert property (@(posedge clk) disable iff (rst)
    latch_rise |=> !latch_rise); // R8

  AST_RESET_CLR: assert property (@(posedge clk)
    rst |=> (!peer_rst && !peer_sdo && regs_flat == '0)); // R9
endmodule

bind serial_bridge_port sbp_checker #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .host_we      (host_we),
  .host_addr    (host_addr),
  .host_wdata   (host_wdata),
  .host_ctl_wr  (host_ctl_wr),
  .host_ctl_bit (host_ctl_bit),
  .peer_rst     (peer_rst),
  .peer_sdo     (peer_sdo),
  .latch_rise   (latch_rise),
  .sclk_rise    (sclk_rise),
  .sel_s        (sel_s),
  .shreg_q      (shreg_q),
  .regs_flat    (regs_flat)
);

// File: tb/serial_bridge_port_test.sv
module serial_bridge_port_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       host_we = 1'b0, host_re = 1'b0;
  logic [7:0] host_rdata;
  logic       host_ctl_wr = 1'b0, host_ctl_bit = 1'b0;
  logic [1:0] peer_sel = '0;
  logic       peer_sclk = 1'b0, peer_latch = 1'b0, peer_sdi = 1'b0;
  logic       peer_sdo, peer_rst;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_bridge_port uut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_re(host_re), .host_rdata(host_rdata),
    .host_ctl_wr(host_ctl_wr), .host_ctl_bit(host_ctl_bit),
    .peer_sel(peer_sel), .peer_sclk(peer_sclk), .peer_latch(peer_latch),
    .peer_sdi(peer_sdi), .peer_sdo(peer_sdo), .peer_rst(peer_rst)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_re = 1'b1;
    @(negedge clk);
    host_re = 1'b0;
    d = host_rdata;
  endtask

  task automatic set_ctl(input logic b);
    @(negedge clk);
    host_ctl_bit = b; host_ctl_wr = 1'b1;
    @(negedge clk);
    host_ctl_wr = 1'b0;
  endtask

  task automatic sclk_pulse();
    @(negedge clk); peer_sclk = 1'b1; settle();
    peer_sclk = 1'b0; settle();
  endtask

  task automatic latch_pulse();
    @(negedge clk); peer_latch = 1'b1; settle();
    peer_latch = 1'b0; settle();
  endtask

  task automatic shift_in(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); peer_sdi = b[i];
      sclk_pulse();
    end
  endtask

  task automatic select(input logic [1:0] s);
    @(negedge clk); peer_sel = s; settle();
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      host_read(2'(a), d);
      check("R9 reset register", d, 8'h00);
    end
    check("R9 reset sdo", {7'd0, peer_sdo}, 8'h00);
    check("R9 reset peer_rst", {7'd0, peer_rst}, 8'h00);
  endtask

  task automatic t_host_rw();
    logic [7:0] d;
    host_write(2'd0, 8'hA5);
    host_write(2'd1, 8'h3E);
    host_read(2'd0, d); check("R2 readback addr0", d, 8'hA5);
    host_read(2'd1, d); check("R2 readback addr1", d, 8'h3E);
    repeat (3) @(negedge clk);
    check("R2 rdata holds", host_rdata, 8'h3E);
  endtask

  task automatic t_outbound(input logic [1:0] s, input logic [7:0] exp);
    select(s);
    latch_pulse();
    check("R3 first bit is MSB", {7'd0, peer_sdo}, {7'd0, exp[7]});
    for (int i = 6; i >= 0; i--) begin
      sclk_pulse();
      check("R3 next bit", {7'd0, peer_sdo}, {7'd0, exp[i]});
    end
  endtask

  task automatic t_inbound();
    logic [7:0] d;
    select(2'd2);
    shift_in(8'h3C);
    latch_pulse();
    host_read(2'd2, d); check("R4 R5 inbound data", d, 8'h3C);
    select(2'd3);
    shift_in(8'hC9);
    latch_pulse();
    host_read(2'd3, d); check("R5 inbound ctrl", d, 8'hC9);
    host_read(2'd2, d); check("R5 other inbound kept", d, 8'h3C);
    host_read(2'd0, d); check("R1 outbound untouched", d, 8'hA5);
  endtask

  task automatic t_latch_held();
    logic [7:0] d;
    select(2'd2);
    shift_in(8'h5B);
    @(negedge clk); peer_latch = 1'b1; settle();
    shift_in(8'h81);
    host_read(2'd2, d); check("R8 held latch no retransfer", d, 8'h5B);
    @(negedge clk); peer_latch = 1'b0; settle();
    latch_pulse();
    host_read(2'd2, d); check("R8 next rise transfers", d, 8'h81);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    select(2'd3);
    @(negedge clk); peer_latch = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); host_addr = 2'd3; host_wdata = 8'h5A; host_we = 1'b1;
    @(negedge clk); host_we = 1'b0;
    settle();
    peer_latch = 1'b0; settle();
    host_read(2'd3, d); check("R6 host write wins", d, 8'h5A);
  endtask

  task automatic t_ctl();
    set_ctl(1'b1);
    check("R7 peer_rst set", {7'd0, peer_rst}, 8'h01);
    set_ctl(1'b0);
    check("R7 peer_rst clear", {7'd0, peer_rst}, 8'h00);
    set_ctl(1'b1);
  endtask

  task automatic t_midreset();
    host_write(2'd0, 8'hFF);
    select(2'd0);
    latch_pulse();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_host_rw();
    t_outbound(2'd0, 8'hA5);
    t_outbound(2'd1, 8'h3E);
    t_inbound();
    t_latch_held();
    t_priority();
    t_ctl();
    t_midreset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule